// File: doc/BRIEF.md
# Narrow-Mode Data Beat Sequencer

This block runs the data phase of a processor bus transfer for a core whose internal data path is 64 bits wide. The bus it drives may be wired at full 64-bit width or at half width. The width is chosen by a strap sampled during reset. A transfer request carries a transfer class (small single, double word, or cache-line burst), a direction, a size code, the low address bits, an instruction-fetch flag and a 256-bit line payload. The sequencer turns the request into the correct number of bus beats. It advances one beat per transfer acknowledge, and reports completion with a single-cycle pulse that carries the assembled read line.

In half-width mode only the upper four byte lanes (bus bits 63:32) carry data. The lower four lanes are driven low on writes and never sampled on reads. The block also computes the window in which a late address retry may still cancel the data phase. A retry seen inside that window aborts the transfer and discards any read data already gathered.

Top module: `narrow_beat_seq`

## Requirements
- R1: `mode_narrow` takes the value of `cfg_narrow` while `rst` is high and keeps it unchanged until `rst` is raised again, whatever `cfg_narrow` does afterwards.
- R2: In narrow mode `bus_dout[31:0]` is always zero, and `bus_din[31:0]` never affects `rd_data`.
- R3: A small transfer (`req_kind`=0) takes one beat with `bus_burst` low and `bus_tsiz` equal to `req_size`. An instruction fetch (`req_ifetch`=1) with `req_kind` 0 or 1 runs as a small transfer with `bus_tsiz`=3'b100.
- R4: A double transfer (`req_kind`=1) takes two beats in narrow mode and one beat in wide mode, with `bus_burst` low and `bus_tsiz`=3'b000. It is refused (`req_ready` low) unless `req_addr`=3'b000.
- R5: A line transfer (`req_kind`=2) takes eight beats in narrow mode and four in wide mode, with `bus_burst` high and `bus_tsiz`=3'b010.
- R6: Payload word i occupies bits [255-32i -: 32]. Line transfers start at word 0 and other transfers at word 6. In beat b, narrow mode moves word start+b on bits 63:32, and wide mode moves words start+2b and start+2b+1 on bits 63:32 and 31:0. Reads place the returned words at the same positions, and all other positions of `rd_data` read zero.
- R7: `beat_idx` advances only on a cycle with `bus_ta` high. `done` pulses for one cycle, the cycle after the acknowledge of the last beat, and `rd_data` holds the assembled line in that cycle.
- R8: Let K be 2 for a narrow double transfer and 1 otherwise. `retry_win` is high while fewer than K beats have been acknowledged, and in the single cycle right after the K-th acknowledge.
- R9: `bus_artry` while `retry_win` is high raises `abort` and returns the block to idle with no `done`, and `rd_data` then reads zero. Outside the window `bus_artry` has no effect.
- R10: `req_ready` is high only while the sequencer is idle; a request is taken on a clock edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | Width strap, 1 = 32-bit bus, sampled during reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 small, 1 double, 2 line, 3 reserved |
| req_ifetch | input | 1 | Request is a cache-bypassing instruction fetch |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Size code for small transfers |
| req_addr | input | 3 | Low address bits |
| req_wdata | input | 256 | Write payload, word 0 in the top bits |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_artry | input | 1 | Late address retry |
| bus_din | input | 64 | Read data from the bus |
| bus_dout | output | 64 | Write data to the bus |
| bus_tsiz | output | 3 | Size code of the running transfer |
| bus_burst | output | 1 | Burst indicator |
| bus_write | output | 1 | Direction of the running transfer |
| busy | output | 1 | A transfer is in progress |
| beat_idx | output | 3 | Index of the current beat |
| retry_win | output | 1 | A retry would cancel the data phase now |
| done | output | 1 | Transfer complete pulse |
| abort | output | 1 | Transfer cancelled pulse |
| rd_data | output | 256 | Assembled read line |
| mode_narrow | output | 1 | Latched bus width mode |

## Verification
Every transfer class is run in both directions and in both bus widths, and the bench compares each beat against arithmetic word mapping. This separates beat-count errors from lane and word-order errors, because each word carries its own index. Garbage is driven on the unused low lanes in narrow mode, which would show up in the read line if it leaked. Acknowledge gaps inside bursts show whether the counter depends on the acknowledge. Retries are placed before the first acknowledge, in the cycle right after the K-th acknowledge, and beyond it, which pins down both edges of the cancellation window for each class. A misaligned double request and fetch requests cover the refusal and size-override rules.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        KIND_SMALL  = 2'd0,
        KIND_DOUBLE = 2'd1,
        KIND_LINE   = 2'd2,
        KIND_RSVD   = 2'd3
    } xkind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_e;

    localparam logic [2:0] TSIZ_DWORD = 3'b000;
    localparam logic [2:0] TSIZ_LINE  = 3'b010;
    localparam logic [2:0] TSIZ_WORD  = 3'b100;

    // Captured view of the running transfer.
    typedef struct packed {
        xkind_e     kind;
        logic       write;
        logic [2:0] tsiz;
        logic       k_two;
    } xfer_desc_t;

    // Cache-bypassing fetches collapse to a single word beat.
    function automatic xkind_e effective_kind(input logic [1:0] kind, input logic ifetch);
        xkind_e k;
        k = xkind_e'(kind);
        if (ifetch && (k == KIND_SMALL || k == KIND_DOUBLE))
            k = KIND_SMALL;
        return k;
    endfunction

    function automatic logic [2:0] bus_size(input xkind_e k, input logic [2:0] sz,
                                            input logic ifetch);
        logic [2:0] r;
        case (k)
            KIND_LINE:   r = TSIZ_LINE;
            KIND_DOUBLE: r = TSIZ_DWORD;
            default:     r = ifetch ? TSIZ_WORD : sz;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nbs_mode_latch.sv
module nbs_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic cfg_narrow,
    output logic narrow
);
    always_ff @(posedge clk) begin
        if (rst)
            narrow <= cfg_narrow;
    end

    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(narrow));
endmodule

// File: rtl/nbs_beat_ctrl.sv
module nbs_beat_ctrl
    import nbs_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             narrow,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_ifetch,
    input  logic             req_write,
    input  logic [2:0]       req_size,
    input  logic [2:0]       req_addr,
    input  logic             ta,
    input  logic             artry,
    output logic             req_ready,
    output logic             accept,
    output logic             busy,
    output logic             in_beat,
    output logic [IDX_W-1:0] beat,
    output logic [IDX_W-1:0] start_word,
    output xfer_desc_t       desc,
    output logic             retry_win,
    output logic             done,
    output logic             abort,
    output logic             cap_en
);
    localparam logic [IDX_W-1:0] LAST_LINE_N = IDX_W'(LINE_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_LINE_W = IDX_W'(LINE_WORDS / 2 - 1);
    localparam logic [IDX_W-1:0] START_PAIR  = IDX_W'(LINE_WORDS - 2);

    seq_state_e       state_q;
    logic [IDX_W-1:0] last_q;
    logic             win_tail_q;

    xkind_e           ek;
    logic             legal;
    logic [IDX_W-1:0] last_d;
    logic [IDX_W-1:0] k_last;

    always_comb begin
        ek    = effective_kind(req_kind, req_ifetch);
        legal = (xkind_e'(req_kind) != KIND_RSVD) &&
                !(ek == KIND_DOUBLE && req_addr != 3'b000);
        case (ek)
            KIND_LINE:   last_d = narrow ? LAST_LINE_N : LAST_LINE_W;
            KIND_DOUBLE: last_d = narrow ? IDX_W'(1) : '0;
            default:     last_d = '0;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE) && legal;
    assign accept    = req_valid && req_ready;
    assign busy      = (state_q != ST_IDLE);
    assign in_beat   = (state_q == ST_BEAT);
    assign k_last    = desc.k_two ? IDX_W'(1) : '0;

    always_comb begin
        retry_win = win_tail_q || (in_beat && (beat == '0 || (desc.k_two && beat == IDX_W'(1))));
        abort     = artry && retry_win;
        done      = (state_q == ST_TAIL) && !abort;
        cap_en    = in_beat && ta && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            beat       <= '0;
            last_q     <= '0;
            start_word <= '0;
            win_tail_q <= 1'b0;
            desc       <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    win_tail_q <= 1'b0;
                    if (accept) begin
                        state_q    <= ST_BEAT;
                        beat       <= '0;
                        last_q     <= last_d;
                        start_word <= (ek == KIND_LINE) ? '0 : START_PAIR;
                        desc.kind  <= ek;
                        desc.write <= req_write;
                        desc.tsiz  <= bus_size(ek, req_size, req_ifetch);
                        desc.k_two <= narrow && (ek == KIND_DOUBLE);
                    end
                end
                ST_BEAT: begin
                    if (abort) begin
                        state_q    <= ST_IDLE;
                        win_tail_q <= 1'b0;
                    end else if (ta) begin
                        win_tail_q <= (beat == k_last);
                        if (beat == last_q)
                            state_q <= ST_TAIL;
                        else
                            beat <= beat + 1'b1;
                    end else begin
                        win_tail_q <= 1'b0;
                    end
                end
                default: begin
                    state_q    <= ST_IDLE;
                    win_tail_q <= 1'b0;
                end
            endcase
        end
    end

    assert_hold_without_ta_R7: assert property (@(posedge clk) disable iff (rst)
        (in_beat && !ta && !abort) |=> (in_beat && beat == $past(beat)));
    assert_done_follows_ta_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ta));
    assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy);
    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !busy);
    assert_line_size_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && desc.kind == KIND_LINE) |-> (desc.tsiz == TSIZ_LINE));
endmodule

// File: rtl/nbs_lane_mux.sv
module nbs_lane_mux #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W  = $clog2(LINE_WORDS),
    localparam int BUS_W  = 2 * WORD_W,
    localparam int LINE_W = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              narrow,
    input  logic              drive,
    input  logic [IDX_W-1:0]  beat,
    input  logic [IDX_W-1:0]  start_word,
    input  logic [LINE_W-1:0] wdata,
    input  logic [BUS_W-1:0]  din,
    input  logic              cap_en,
    input  logic              clear,
    output logic [BUS_W-1:0]  dout,
    output logic [LINE_W-1:0] rd_data
);
    logic [WORD_W-1:0] wword [LINE_WORDS];
    logic [WORD_W-1:0] rword [LINE_WORDS];
    logic [IDX_W-1:0]  w_hi;
    logic [IDX_W-1:0]  w_lo;

    assign w_hi = start_word + (narrow ? beat : IDX_W'(beat << 1));
    assign w_lo = w_hi + 1'b1;

    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
        assign wword[i] = wdata[LINE_W-1-i*WORD_W -: WORD_W];
        assign rd_data[LINE_W-1-i*WORD_W -: WORD_W] = rword[i];

        always_ff @(posedge clk) begin
            if (rst || clear)
                rword[i] <= '0;
            else if (cap_en && w_hi == IDX_W'(i))
                rword[i] <= din[BUS_W-1 -: WORD_W];
            else if (cap_en && !narrow && w_lo == IDX_W'(i))
                rword[i] <= din[WORD_W-1:0];
        end
    end

    always_comb begin
        dout = '0;
        if (drive) begin
            dout[BUS_W-1 -: WORD_W] = wword[w_hi];
            if (!narrow)
                dout[WORD_W-1:0] = wword[w_lo];
        end
    end
endmodule

// File: rtl/narrow_beat_seq.sv
module narrow_beat_seq
    import nbs_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W  = $clog2(LINE_WORDS),
    localparam int BUS_W  = 2 * WORD_W,
    localparam int LINE_W = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_narrow,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_ifetch,
    input  logic              req_write,
    input  logic [2:0]        req_size,
    input  logic [2:0]        req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic              bus_ta,
    input  logic              bus_artry,
    input  logic [BUS_W-1:0]  bus_din,
    output logic [BUS_W-1:0]  bus_dout,
    output logic [2:0]        bus_tsiz,
    output logic              bus_burst,
    output logic              bus_write,
    output logic              busy,
    output logic [IDX_W-1:0]  beat_idx,
    output logic              retry_win,
    output logic              done,
    output logic              abort,
    output logic [LINE_W-1:0] rd_data,
    output logic              mode_narrow
);
    logic             accept;
    logic             in_beat;
    logic             cap_en;
    logic [IDX_W-1:0] start_word;
    xfer_desc_t       desc;

    nbs_mode_latch u_mode (
        .clk        (clk),
        .rst        (rst),
        .cfg_narrow (cfg_narrow),
        .narrow     (mode_narrow)
    );

    nbs_beat_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .narrow     (mode_narrow),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_ifetch (req_ifetch),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .ta         (bus_ta),
        .artry      (bus_artry),
        .req_ready  (req_ready),
        .accept     (accept),
        .busy       (busy),
        .in_beat    (in_beat),
        .beat       (beat_idx),
        .start_word (start_word),
        .desc       (desc),
        .retry_win  (retry_win),
        .done       (done),
        .abort      (abort),
        .cap_en     (cap_en)
    );

    nbs_lane_mux #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .narrow     (mode_narrow),
        .drive      (in_beat && desc.write),
        .beat       (beat_idx),
        .start_word (start_word),
        .wdata      (req_wdata),
        .din        (bus_din),
        .cap_en     (cap_en),
        .clear      (accept || abort),
        .dout       (bus_dout),
        .rd_data    (rd_data)
    );

    assign bus_tsiz  = busy ? desc.tsiz : 3'b000;
    assign bus_burst = busy && (desc.kind == KIND_LINE);
    assign bus_write = busy && desc.write;

    assert_low_lanes_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        mode_narrow |-> (bus_dout[WORD_W-1:0] == '0));
    assert_burst_encoding_R5: assert property (@(posedge clk) disable iff (rst)
        bus_burst |-> (bus_tsiz == TSIZ_LINE));
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/narrow_beat_seq_tb.sv
module narrow_beat_seq_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_narrow = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_kind = 2'd0;
    logic         req_ifetch = 1'b0;
    logic         req_write = 1'b0;
    logic [2:0]   req_size = 3'b100;
    logic [2:0]   req_addr = 3'b000;
    logic [255:0] req_wdata = '0;
    logic         bus_ta = 1'b0;
    logic         bus_artry = 1'b0;
    logic [63:0]  bus_din = '0;
    logic [63:0]  bus_dout;
    logic [2:0]   bus_tsiz;
    logic         bus_burst;
    logic         bus_write;
    logic         busy;
    logic [2:0]   beat_idx;
    logic         retry_win;
    logic         done;
    logic         abort;
    logic [255:0] rd_data;
    logic         mode_narrow;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;
    bit cur_mode = 0;

    always #4 clk = ~clk;

    narrow_beat_seq u_dut (
        .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_ifetch(req_ifetch), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_ta(bus_ta),
        .bus_artry(bus_artry), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_tsiz(bus_tsiz), .bus_burst(bus_burst), .bus_write(bus_write),
        .busy(busy), .beat_idx(beat_idx), .retry_win(retry_win), .done(done),
        .abort(abort), .rd_data(rd_data), .mode_narrow(mode_narrow)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wword(input int i, input logic [7:0] seed);
        return {seed, 8'(i), 16'hBE00 + 16'(i * 16'h0111)};
    endfunction
    function automatic logic [31:0] rword(input int i, input logic [7:0] seed);
        return {seed ^ 8'hD0, 8'(i + 8'h40), 16'h7E00 + 16'(i)};
    endfunction

    task automatic do_reset(input bit narrow);
        @(negedge clk);
        rst = 1'b1;
        cfg_narrow = narrow;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_narrow = ~narrow;
        cur_mode = narrow;
        @(negedge clk);
        check(mode_narrow == narrow, "R1 mode latched", 256'(mode_narrow), 256'(narrow));
        check(!busy && !done && !abort && bus_dout == 0 && rd_data == 0, "R10 reset idle",
              256'({busy, done, abort}), 256'(0));
    endtask

    // retry_at: acks completed when retry is raised; -1 = none
    task automatic xfer(input logic [1:0] kind, input bit wr, input logic [2:0] sz,
                        input bit ifetch, input int retry_at, input bit gap,
                        input logic [7:0] seed);
        int ek, n, k, st, step, w;
        bit win, aborted;
        logic [2:0] exp_tsiz;
        logic [255:0] exp_rd;
        logic [63:0] exp_out;
        ek = (ifetch && kind != 2) ? 0 : int'(kind);
        n  = (ek == 2) ? (cur_mode ? 8 : 4) : (ek == 1) ? (cur_mode ? 2 : 1) : 1;
        k  = (ek == 1 && cur_mode) ? 2 : 1;
        st = (ek == 2) ? 0 : 6;
        step = cur_mode ? 1 : 2;
        exp_tsiz = (ek == 2) ? 3'b010 : (ek == 1) ? 3'b000 : (ifetch ? 3'b100 : sz);
        for (int i = 0; i < 8; i++) req_wdata[255 - 32*i -: 32] = wword(i, seed);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_write = wr; req_size = sz;
        req_ifetch = ifetch; req_addr = 3'b000;
        check(req_ready == 1'b1, "R10 ready when idle", 256'(req_ready), 256'(1));
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !req_ready, "R10 not ready while busy", 256'({busy, req_ready}), 256'(2'b10));
        check(bus_tsiz == exp_tsiz, "R3 R4 R5 size code", 256'(bus_tsiz), 256'(exp_tsiz));
        check(bus_burst == (ek == 2), "R5 burst flag", 256'(bus_burst), 256'(ek == 2));
        check(bus_write == wr, "R6 direction", 256'(bus_write), 256'(wr));
        exp_rd = '0;
        aborted = 0;
        for (int b = 0; b < n && !aborted; b++) begin
            w = st + b * step;
            if (gap && b == 1) begin
                @(negedge clk);
                check(beat_idx == 3'(b), "R7 hold without ta", 256'(beat_idx), 256'(b));
            end
            check(beat_idx == 3'(b), "R7 beat index", 256'(beat_idx), 256'(b));
            if (wr) begin
                exp_out = cur_mode ? {wword(w, seed), 32'h0} : {wword(w, seed), wword(w + 1, seed)};
                check(bus_dout == exp_out, "R6 R2 write lanes", 256'(bus_dout), 256'(exp_out));
            end
            if (retry_at == b) begin
                win = (b <= k);
                bus_artry = 1'b1;
                #1;
                check(abort == win, "R8 R9 retry window", 256'(abort), 256'(win));
                @(negedge clk);
                bus_artry = 1'b0;
                if (win) begin
                    check(!busy && !done && rd_data == 0, "R9 abort discards",
                          rd_data, 256'(0));
                    aborted = 1;
                    continue;
                end
                check(busy && beat_idx == 3'(b), "R9 retry ignored", 256'(beat_idx), 256'(b));
            end
            bus_din = cur_mode ? {rword(w, seed), 32'hFFFF_A5A5 ^ 32'(b)}
                               : {rword(w, seed), rword(w + 1, seed)};
            exp_rd[255 - 32*w -: 32] = rword(w, seed);
            if (!cur_mode) exp_rd[255 - 32*(w+1) -: 32] = rword(w + 1, seed);
            bus_ta = 1'b1;
            @(negedge clk);
            bus_ta = 1'b0;
        end
        if (!aborted) begin
            if (retry_at == n) begin
                win = (n <= k);
                bus_artry = 1'b1;
                #1;
                check(abort == win && done == !win, "R8 R9 tail retry",
                      256'({abort, done}), 256'({win, !win}));
            end else begin
                check(done == 1'b1, "R7 done after last ta", 256'(done), 256'(1));
                if (!wr) check(rd_data == exp_rd, "R6 R2 read line", rd_data, exp_rd);
            end
            @(negedge clk);
            bus_artry = 1'b0;
            check(!done && !busy, "R7 single done pulse", 256'({done, busy}), 256'(0));
            if (retry_at == n && n <= k)
                check(rd_data == 0, "R9 abort clears line", rd_data, 256'(0));
        end
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            for (int kd = 0; kd < 3; kd++)
                for (int wr = 0; wr < 2; wr++)
                    xfer(2'(kd), wr[0], (kd == 0) ? 3'b011 : 3'b000, 0, -1,
                         kd == 2, 8'(16 * m + 4 * kd + wr));
            check(mode_narrow == m[0], "R1 mode held", 256'(mode_narrow), 256'(m));
            // misaligned double refused
            @(negedge clk);
            req_valid = 1'b1; req_kind = 2'd1; req_addr = 3'b100; req_ifetch = 1'b0;
            #1;
            check(!req_ready, "R4 misaligned refused", 256'(req_ready), 256'(0));
            @(negedge clk);
            check(!busy, "R4 misaligned not started", 256'(busy), 256'(0));
            req_valid = 1'b0; req_addr = 3'b000;
            // cache-bypassing fetches
            xfer(2'd0, 0, 3'b001, 1, -1, 0, 8'h61);
            xfer(2'd1, 0, 3'b000, 1, -1, 0, 8'h62);
            // retry window edges
            xfer(2'd1, 0, 3'b000, 0, 0, 0, 8'h70);
            xfer(2'd1, 0, 3'b000, 0, 1, 0, 8'h71);
            xfer(2'd0, 0, 3'b010, 0, 1, 0, 8'h72);
            xfer(2'd2, 0, 3'b000, 0, 1, 0, 8'h73);
            xfer(2'd2, 0, 3'b000, 0, 2, 0, 8'h74);
            xfer(2'd2, 1, 3'b000, 0, 3, 0, 8'h75);
            if (m == 1) xfer(2'd1, 0, 3'b000, 0, 2, 0, 8'h76);
            xfer(2'd0, 1, 3'b100, 0, -1, 0, 8'h77);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule